// File: doc/BRIEF.md
# Inter-processor mailbox channel controller

This block lets several processors exchange short messages and interrupts through a bank of memory-mapped mailbox channels. Each channel has its own 64-byte register window. A processor claims a channel by writing its own one-hot acknowledge bit into the channel's source register. It then picks the destination interrupt vectors and the masking, loads an eight-word payload and fires the transfer by writing its bit to the send register. The receiving side reads the payload and clears its interrupt through the destination-clear register. In automatic-acknowledge mode, the channel then raises the owner's acknowledge interrupt. The owner retires that acknowledge through the interrupt-clear register, and the channel is ready for the next message.

Configuration needs the mailbox to be unlocked first. After reset a global lock register at 0xA00 holds the mailbox locked. Writing the 32-bit key 0x1ACCE551 there unlocks it, and writing any other value locks it again. The register port is a plain single-cycle bus with no back-pressure: it accepts every request in the cycle it is presented. A write takes effect at that clock edge, and read data is returned combinationally in the same cycle. The interrupt output carries one bit per vector index. Each bit is the OR, over all channels, of the pending destination interrupts and the acknowledge interrupts.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the lock register reads 1, every channel's mode register reads 0x10 (idle) and `irq_vec` is 0.
- R2: A write of 0x1ACCE551 to address 0xA00 makes that register read 0 (unlocked). A write of any other value there makes it read 1 (locked).
- R3: While locked, writes to the source (0x00), destination (0x04), mode (0x10), mask (0x14), send (0x1C) and data (0x20..0x3C) registers have no effect. The destination-clear (0x08) and interrupt-clear (0x18) registers still work.
- R4: Writing a one-hot value to the source register of an idle channel claims it: source reads that value and mode reads 0x20. A source write that is not one-hot, or one made while the channel is not idle, is ignored.
- R5: The mode register reads bit 0 = automatic-acknowledge enable, bit 4 = idle, bit 5 = ready and bit 7 = acknowledge pending. Writing bit 0 is accepted only while the channel is ready.
- R6: Payload word i (i = 0..7) is at window offset 0x20 + 4*i and reads back what was written. Payload writes are accepted only while the channel is ready.
- R7: In the ready state, writing exactly the owner's bit to send (0x1C) latches pending = destination AND NOT mask, where a mask bit of 1 means masked. Destination status (0x0C) then reads that pending value. A send write with any other value is ignored.
- R8: Destination-clear writes clear pending bits wherever the written value has a 1. When pending reaches zero, an automatic-acknowledge channel enters the acknowledge state and mode reads 0x81. A channel without automatic acknowledge returns to ready (mode 0x20) with no acknowledge.
- R9: In the acknowledge state, an interrupt-clear write that contains the owner's bit drops the acknowledge and returns the channel to ready. An interrupt-clear write without that bit is ignored.
- R10: Writing zero to the source register of a ready channel releases it: source, destination and the mode enable bit read 0, and mode reads 0x10.
- R11: `irq_vec` bit k is 1 when any channel has destination bit k pending, or is in the acknowledge state with owner bit k.
- R12: The channel index is address bits [11:6]. Windows with an index at or above the channel count read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access request, accepted the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address (channel in [11:6], offset in [5:0]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_vec | output | 32 | Per-vector interrupt lines, OR over all channels |

## Verification
The bench builds the block with three channels. This leaves window index 3 decoded but unimplemented, so the read-as-zero and ignored-write behaviour of out-of-range windows can be reached. Three live channels are enough to hold two transfers open at once and check that their vectors combine on `irq_vec`. Random owners, destinations, masks and mode choices cover the case where every destination is masked, in which the channel passes through the sent state without any pending bit.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned OFF_W  = 6;
  localparam int unsigned IDX_W  = ADDR_W - OFF_W;

  localparam logic [OFF_W-1:0] OFF_SRC   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_DST   = 6'h04;
  localparam logic [OFF_W-1:0] OFF_DCLR  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_DSTAT = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_MODE  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_MASK  = 6'h14;
  localparam logic [OFF_W-1:0] OFF_ICLR  = 6'h18;
  localparam logic [OFF_W-1:0] OFF_SEND  = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_DATA  = 6'h20;

  localparam logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00;
  localparam logic [WORD_W-1:0] LOCK_KEY  = 32'h1ACC_E551;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_SENT  = 2'd2,
    ST_ACK   = 2'd3
  } mbx_state_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  ch_idx,
  output logic [OFF_W-1:0]  ch_off,
  output logic              ch_hit,
  output logic              lock_hit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH);

  assign ch_idx   = addr[ADDR_W-1:OFF_W];
  assign ch_off   = addr[OFF_W-1:0];
  assign ch_hit   = (ch_idx < LAST_IDX);
  assign lock_hit = (addr == LOCK_ADDR);
endmodule

// File: rtl/mbx_lock.sv
module mbx_lock
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic              locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     locked <= 1'b1;
    else if (wr_en) locked <= (wdata != LOCK_KEY);
  end

  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == LOCK_KEY) |=> !locked);
  a_r2_other_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != LOCK_KEY) |=> locked);
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int unsigned MSG_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wdata,
  input  logic              locked,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] irq_o
);
  localparam int unsigned MW_IDX = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;

  mbx_state_e        st_q, st_n;
  logic [WORD_W-1:0] src_q, src_n, dst_q, dst_n, mask_q, mask_n;
  logic [WORD_W-1:0] pend_q, pend_n, ack_q, ack_n;
  logic              auto_q, auto_n;
  logic [WORD_W-1:0] data_q [MSG_WORDS];

  logic              cfg_ok, data_sel;
  logic [MW_IDX-1:0] word_idx;

  assign cfg_ok   = wr_en && !locked;
  assign word_idx = off[2 +: MW_IDX];
  assign data_sel = (off >= OFF_DATA) && (off[1:0] == 2'b00)
                    && (32'(word_idx) < MSG_WORDS)
                    && ((off - OFF_DATA) >> 2) == OFF_W'(word_idx);

  always_comb begin
    st_n = st_q; src_n = src_q; dst_n = dst_q; mask_n = mask_q;
    pend_n = pend_q; ack_n = ack_q; auto_n = auto_q;
    if (cfg_ok) begin
      unique case (off)
        OFF_SRC: begin
          if (st_q == ST_IDLE && $onehot(wdata)) begin
            src_n = wdata; st_n = ST_READY;
          end else if (st_q == ST_READY && wdata == '0) begin
            src_n = '0; dst_n = '0; auto_n = 1'b0; st_n = ST_IDLE;
          end
        end
        OFF_DST:  if (st_q == ST_READY) dst_n  = wdata;
        OFF_MODE: if (st_q == ST_READY) auto_n = wdata[0];
        OFF_MASK: if (st_q == ST_READY) mask_n = wdata;
        OFF_SEND: if (st_q == ST_READY && wdata == src_q) begin
          pend_n = dst_q & ~mask_q; st_n = ST_SENT;
        end
        default: ;
      endcase
    end
    if (wr_en && off == OFF_DCLR) pend_n = pend_q & ~wdata;
    if (wr_en && off == OFF_ICLR && st_q == ST_ACK && (wdata & src_q) != '0) begin
      ack_n = '0; st_n = ST_READY;
    end
    if (st_n == ST_SENT && pend_n == '0) begin
      if (auto_n) begin st_n = ST_ACK; ack_n = src_n; end
      else        st_n = ST_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; src_q <= '0; dst_q <= '0; mask_q <= '0;
      pend_q <= '0; ack_q <= '0; auto_q <= 1'b0;
    end else begin
      st_q <= st_n; src_q <= src_n; dst_q <= dst_n; mask_q <= mask_n;
      pend_q <= pend_n; ack_q <= ack_n; auto_q <= auto_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MSG_WORDS; i++) data_q[i] <= '0;
    end else if (cfg_ok && st_q == ST_READY && data_sel) begin
      data_q[word_idx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (off)
      OFF_SRC:   rdata = src_q;
      OFF_DST:   rdata = dst_q;
      OFF_DSTAT: rdata = pend_q;
      OFF_MODE:  rdata = {24'd0, st_q == ST_ACK, 1'b0, st_q == ST_READY,
                          st_q == ST_IDLE, 3'd0, auto_q};
      OFF_MASK:  rdata = mask_q;
      default:   if (data_sel) rdata = data_q[word_idx];
    endcase
  end

  assign irq_o = pend_q | ack_q;

  a_r3_locked_no_config: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked) |=> ($stable(src_q) && $stable(dst_q) && $stable(mask_q)
                           && $stable(auto_q)));
  a_r4_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_q));
  a_r7_pend_only_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SENT) |-> (pend_q == '0));
  a_r7_pend_respects_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & mask_q) == '0);
  a_r8_ack_is_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK) |-> (auto_q && ack_q == src_q));
  a_r10_idle_no_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (src_q == '0 && dst_q == '0 && ack_q == '0));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned MSG_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       irq_vec
);
  logic [IDX_W-1:0]  ch_idx;
  logic [OFF_W-1:0]  ch_off;
  logic              ch_hit, lock_hit, locked;
  logic [WORD_W-1:0] ch_rd  [NCH];
  logic [WORD_W-1:0] ch_irq [NCH];

  mbx_decode #(.NCH(NCH)) u_dec (
    .addr(bus_addr), .ch_idx(ch_idx), .ch_off(ch_off),
    .ch_hit(ch_hit), .lock_hit(lock_hit)
  );

  mbx_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_en && bus_we && lock_hit),
    .wdata(bus_wdata), .locked(locked)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mbx_channel #(.MSG_WORDS(MSG_WORDS)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_en && bus_we && ch_hit && ch_idx == IDX_W'(g)),
      .off(ch_off), .wdata(bus_wdata), .locked(locked),
      .rdata(ch_rd[g]), .irq_o(ch_irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (lock_hit) bus_rdata = {31'd0, locked};
    else
      for (int i = 0; i < NCH; i++)
        if (ch_hit && ch_idx == IDX_W'(i)) bus_rdata = ch_rd[i];
  end

  always_comb begin
    irq_vec = '0;
    for (int i = 0; i < NCH; i++) irq_vec = irq_vec | ch_irq[i];
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bus_en && bus_we && lock_hit));
  a_r12_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_hit && !lock_hit) |-> (bus_rdata == '0));
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  localparam int NCH = 3;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, irq_vec;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox #(.NCH(NCH), .MSG_WORDS(8)) i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_vec(irq_vec)
  );

  function automatic logic [11:0] ra(int ch, int off);
    return 12'(ch * 64 + off);
  endfunction

  function automatic logic [31:0] mode_word(bit idle, bit rdy, bit ack, bit au);
    return {24'd0, ack, 1'b0, rdy, idle, 3'd0, au};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic chk_rd(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_rd("R1 lock", 12'hA00, 32'd1);
    for (int c = 0; c < NCH; c++) chk_rd("R1 mode", ra(c, 'h10), 32'h10);
    chk("R1 irq", irq_vec, 32'd0);
    // R3 claim while locked
    wr(ra(0, 0), 32'h4);
    chk_rd("R3 src locked", ra(0, 0), 32'd0);
    chk_rd("R3 mode locked", ra(0, 'h10), 32'h10);
    // R2 key handling
    wr(12'hA00, 32'h1234_5678);
    chk_rd("R2 wrong key", 12'hA00, 32'd1);
    wr(12'hA00, KEY);
    chk_rd("R2 unlocked", 12'hA00, 32'd0);
    // R4 claiming
    wr(ra(0, 0), 32'h3);
    chk_rd("R4 not onehot", ra(0, 0), 32'd0);
    wr(ra(0, 0), 32'h4);
    chk_rd("R4 claimed src", ra(0, 0), 32'h4);
    chk_rd("R4 claimed mode", ra(0, 'h10), 32'h20);
    wr(ra(0, 0), 32'h8);
    chk_rd("R4 second claim", ra(0, 0), 32'h4);
    // R5, R6
    wr(ra(0, 'h10), 32'h1);
    chk_rd("R5 auto bit", ra(0, 'h10), 32'h21);
    for (int i = 0; i < 8; i++) wr(ra(0, 'h20 + 4 * i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) chk_rd("R6 payload", ra(0, 'h20 + 4 * i), 32'hA000_0000 + 32'(i));
    wr(ra(1, 'h20), 32'hDEAD_BEEF);
    chk_rd("R6 idle payload ignored", ra(1, 'h20), 32'd0);
    // R7 send
    wr(ra(0, 'h04), 32'h13);
    wr(ra(0, 'h14), 32'h2);
    wr(ra(0, 'h1C), 32'h8);
    chk_rd("R7 wrong send", ra(0, 'h10), 32'h21);
    wr(ra(0, 'h1C), 32'h4);
    chk_rd("R7 dstat", ra(0, 'h0C), 32'h11);
    chk("R11 irq dest", irq_vec, 32'h11);
    chk_rd("R5 sent mode", ra(0, 'h10), 32'h01);
    // R8 clear destination
    wr(ra(0, 'h08), 32'h1);
    chk_rd("R8 partial", ra(0, 'h0C), 32'h10);
    chk_rd("R8 still sent", ra(0, 'h10), 32'h01);
    wr(ra(0, 'h08), 32'h10);
    chk_rd("R8 ack mode", ra(0, 'h10), 32'h81);
    chk("R11 irq ack", irq_vec, 32'h4);
    // R9
    wr(ra(0, 'h18), 32'h8);
    chk_rd("R9 wrong iclr", ra(0, 'h10), 32'h81);
    wr(ra(0, 'h18), 32'h4);
    chk_rd("R9 ready", ra(0, 'h10), 32'h21);
    chk("R9 irq off", irq_vec, 32'd0);
    // R10 release
    wr(ra(0, 0), 32'd0);
    chk_rd("R10 mode", ra(0, 'h10), 32'h10);
    chk_rd("R10 dst", ra(0, 'h04), 32'd0);
    chk_rd("R10 src", ra(0, 0), 32'd0);
    // R8 without automatic acknowledge
    wr(ra(1, 0), 32'h1); wr(ra(1, 'h04), 32'h40); wr(ra(1, 'h1C), 32'h1);
    chk("R8 manual irq", irq_vec, 32'h40);
    wr(ra(1, 'h08), 32'h40);
    chk_rd("R8 manual ready", ra(1, 'h10), 32'h20);
    chk("R8 manual no ack", irq_vec, 32'd0);
    // R11 two channels at once
    wr(ra(2, 0), 32'h2); wr(ra(2, 'h04), 32'h100); wr(ra(2, 'h1C), 32'h2);
    wr(ra(1, 'h04), 32'h1); wr(ra(1, 'h1C), 32'h1);
    chk("R11 combined", irq_vec, 32'h101);
    wr(ra(2, 'h08), 32'h100); wr(ra(1, 'h08), 32'h1);
    wr(ra(1, 0), 32'd0); wr(ra(2, 0), 32'd0);
    // R12 out-of-range window
    wr(ra(3, 0), 32'h1);
    chk_rd("R12 window3 src", ra(3, 0), 32'd0);
    chk_rd("R12 window3 mode", ra(3, 'h10), 32'd0);
    // R3 relocked config ignored
    wr(ra(0, 0), 32'h10);
    wr(12'hA00, 32'd0);
    chk_rd("R2 relock", 12'hA00, 32'd1);
    wr(ra(0, 'h04), 32'hFF);
    chk_rd("R3 dst locked", ra(0, 'h04), 32'd0);
    wr(ra(0, 0), 32'd0);
    chk_rd("R3 release locked", ra(0, 0), 32'h10);
    wr(12'hA00, KEY);
    wr(ra(0, 0), 32'd0);
    // random transfers
    for (int it = 0; it < 40; it++) begin
      int c = int'($urandom_range(0, NCH - 1));
      logic [31:0] own = 32'd1 << $urandom_range(0, 31);
      logic [31:0] dst = $urandom, msk = $urandom, pend, w;
      bit au = 1'($urandom_range(0, 1));
      int wi = int'($urandom_range(0, 7));
      if (it % 5 == 0) msk = dst;
      pend = dst & ~msk;
      wr(ra(c, 0), own);
      chk_rd("R4 random claim", ra(c, 0), own);
      wr(ra(c, 'h10), {31'd0, au});
      wr(ra(c, 'h14), msk);
      wr(ra(c, 'h04), dst);
      w = $urandom;
      wr(ra(c, 'h20 + 4 * wi), w);
      chk_rd("R6 random word", ra(c, 'h20 + 4 * wi), w);
      wr(ra(c, 'h1C), own);
      if (pend != 0) begin
        chk_rd("R7 random dstat", ra(c, 'h0C), pend);
        chk("R11 random irq", irq_vec, pend);
        wr(ra(c, 'h08), pend & 32'h0000_FFFF);
        if ((pend & 32'hFFFF_0000) != 0) begin
          chk_rd("R8 random partial", ra(c, 'h0C), pend & 32'hFFFF_0000);
          wr(ra(c, 'h08), 32'hFFFF_0000);
        end
      end
      chk_rd("R8 random end", ra(c, 'h10), mode_word(0, !au, au, au));
      chk("R11 random ack irq", irq_vec, au ? own : 32'd0);
      if (au) wr(ra(c, 'h18), own);
      chk_rd("R9 random ready", ra(c, 'h10), mode_word(0, 1, 0, au));
      wr(ra(c, 0), 32'd0);
      chk_rd("R10 random release", ra(c, 'h10), 32'h10);
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule